// File: doc/BRIEF.md
# Vector Even/Odd Unzip Permute Unit

This unit deinterleaves two source vectors. It picks either the even-indexed or the odd-indexed elements of each source. The picks from the first source are packed into the low part of the destination, and the picks from the second source are packed directly after them. Element width is chosen at run time from four power-of-two widths, or set to 128 bits by a quadword mode. The active vector length is also chosen at run time, in 128-bit granules, up to a parameterised maximum.

A caller presents both sources and the control fields, then pulses `start` for one cycle. One cycle later the unit raises `done` for one cycle. At the same time it presents the registered result and an `undef` flag. The flag reports an illegal combination of length, width and mode. When `undef` is set, the result is all zeros. Between starts the outputs hold their last values.

Control is a two-state machine. In `ST_IDLE` no result is being presented. In `ST_EMIT` the result captured on the previous edge is being presented. The transition `GO` takes any state to `ST_EMIT` on a `start` pulse. The transition `REST` takes any state to `ST_IDLE` when `start` is low.

Top module: `vec_unzip`

## Requirements
- R1: The element width is 8, 16, 32 or 64 bits for `size_code` 0, 1, 2 or 3. When `quad_mode` is 1 the width is 128 bits and `size_code` is ignored.
- R2: `odd_sel`=0 selects source elements 0,2,4,…. `odd_sel`=1 selects source elements 1,3,5,…. Element i occupies bits [i*W +: W], where W is the element width.
- R3: With VL = 128*`vl_gran` and pairs = VL/(2W), result element p is `src_a` element 2p+`odd_sel`, and result element pairs+p is `src_b` element 2p+`odd_sel`, for p in 0..pairs-1.
- R4: Result bits at positions VL and above are zero.
- R5: `vl_gran` equal to 0, or greater than VLEN_MAX/128, sets `undef`. For widths up to 64, every `vl_gran` from 1 to VLEN_MAX/128 is legal.
- R6: `quad_mode`=1 with `vl_gran` < 2 (VL below 256) sets `undef`.
- R7: `quad_mode`=1 with `streaming`=1 and `full_feat`=0 sets `undef`. With `full_feat`=1 the same case is legal. `streaming` has no effect when `quad_mode`=0.
- R8: When `undef` is 1, `result` is all zeros.
- R9: `done` is high exactly in the cycle after each cycle in which `start` was high at the clock edge. `result` and `undef` change only on those edges, so later changes to the inputs do not disturb them.
- R10: A synchronous active-high `rst` clears `done`, `undef` and `result`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Sample the inputs on this edge |
| src_a | input | VLEN_MAX | First source vector |
| src_b | input | VLEN_MAX | Second source vector |
| vl_gran | input | $clog2(VLEN_MAX/128+1) | Active length in 128-bit granules |
| size_code | input | 2 | Element width code |
| quad_mode | input | 1 | Force 128-bit elements |
| odd_sel | input | 1 | 0 = even elements, 1 = odd elements |
| streaming | input | 1 | Streaming mode is active |
| full_feat | input | 1 | Full feature set is enabled in streaming mode |
| done | output | 1 | Result valid strobe |
| undef | output | 1 | Illegal-operation flag |
| result | output | VLEN_MAX | Destination vector |

## Verification
The bench builds the unit with the default VLEN_MAX of 512. That gives four legal granule counts, so every width sees several pair counts. The 8-bit width reaches 32 pairs and the quadword width is shown at exactly one and two pairs. The 3-bit `vl_gran` port can also carry the out-of-range codes 0 and 5 to 7, which lets the bench reach every illegal-length case. Quadword mode is swept over all four combinations of streaming and full-feature enable.

// File: rtl/vec_unzip_pkg.sv
package vec_unzip_pkg;
    localparam int GRANULE   = 128;
    localparam int NUM_WIDTH = 5;
    localparam int QUAD_IDX  = 4;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } unzip_state_e;

    function automatic int width_of(input int idx);
        return (idx == QUAD_IDX) ? 128 : (8 << idx);
    endfunction
endpackage

// File: rtl/unzip_legal.sv
module unzip_legal #(
    parameter int GRAN_MAX = 4,
    parameter int GW       = 3
) (
    input  logic [GW-1:0] vl_gran,
    input  logic          quad_mode,
    input  logic          streaming,
    input  logic          full_feat,
    output logic          bad
);
    logic len_bad, quad_short, quad_stream;

    always_comb begin
        len_bad     = (vl_gran == '0) || (int'(vl_gran) > GRAN_MAX);
        quad_short  = quad_mode && (int'(vl_gran) < 2);
        quad_stream = quad_mode && streaming && !full_feat;
        bad         = len_bad || quad_short || quad_stream;
    end
endmodule

// File: rtl/unzip_perm.sv
module unzip_perm #(
    parameter int VLEN_MAX = 512,
    parameter int ES       = 8,
    parameter int GW       = 3
) (
    input  logic [VLEN_MAX-1:0] src_a,
    input  logic [VLEN_MAX-1:0] src_b,
    input  logic [GW-1:0]       vl_gran,
    input  logic                odd_sel,
    output logic [VLEN_MAX-1:0] perm_out
);
    import vec_unzip_pkg::*;

    localparam int NUM_EL   = VLEN_MAX / ES;
    localparam int MAX_PAIR = NUM_EL / 2;

    int pairs;

    always_comb begin
        pairs = (int'(vl_gran) * GRANULE) / (2 * ES);
        if (pairs > MAX_PAIR) pairs = MAX_PAIR;
        perm_out = '0;
        for (int p = 0; p < MAX_PAIR; p++) begin
            if (p < pairs) begin
                perm_out[p*ES +: ES] =
                    src_a[(2*p + int'(odd_sel))*ES +: ES];
                perm_out[(pairs + p)*ES +: ES] =
                    src_b[(2*p + int'(odd_sel))*ES +: ES];
            end
        end
    end
endmodule

// File: rtl/vec_unzip.sv
module vec_unzip #(
    parameter int VLEN_MAX = 512,
    parameter int GRAN_MAX = VLEN_MAX / 128,
    parameter int GW       = $clog2(GRAN_MAX + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [VLEN_MAX-1:0] src_a,
    input  logic [VLEN_MAX-1:0] src_b,
    input  logic [GW-1:0]       vl_gran,
    input  logic [1:0]          size_code,
    input  logic                quad_mode,
    input  logic                odd_sel,
    input  logic                streaming,
    input  logic                full_feat,
    output logic                done,
    output logic                undef,
    output logic [VLEN_MAX-1:0] result
);
    import vec_unzip_pkg::*;

    unzip_state_e state_q, state_d;
    logic [VLEN_MAX-1:0] cand [NUM_WIDTH];
    logic [VLEN_MAX-1:0] picked;
    logic                bad;

    for (genvar k = 0; k < NUM_WIDTH; k++) begin : g_width
        unzip_perm #(
            .VLEN_MAX(VLEN_MAX),
            .ES      (width_of(k)),
            .GW      (GW)
        ) u_perm (
            .src_a   (src_a),
            .src_b   (src_b),
            .vl_gran (vl_gran),
            .odd_sel (odd_sel),
            .perm_out(cand[k])
        );
    end

    unzip_legal #(.GRAN_MAX(GRAN_MAX), .GW(GW)) u_legal (
        .vl_gran  (vl_gran),
        .quad_mode(quad_mode),
        .streaming(streaming),
        .full_feat(full_feat),
        .bad      (bad)
    );

    always_comb begin
        picked = quad_mode ? cand[QUAD_IDX] : cand[size_code];
    end

    // next-state logic: GO and REST transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = start ? ST_EMIT : ST_IDLE;
            ST_EMIT: state_d = start ? ST_EMIT : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // output register: captures on start only
    always_ff @(posedge clk) begin
        if (rst) begin
            undef  <= 1'b0;
            result <= '0;
        end else if (start) begin
            undef  <= bad;
            result <= bad ? '0 : picked;
        end
    end

    assign done = (state_q == ST_EMIT);

    assert_done_follows_start_R9: assert property (@(posedge clk) disable iff (rst)
        start |=> done);
    assert_done_needs_start_R9: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(start));
    assert_hold_outputs_R9: assert property (@(posedge clk) disable iff (rst)
        !start |=> ($stable(result) && $stable(undef)));
    assert_undef_zero_R8: assert property (@(posedge clk) disable iff (rst)
        undef |-> (result == '0));
    assert_quad_stream_R7: assert property (@(posedge clk) disable iff (rst)
        (start && quad_mode && streaming && !full_feat) |=> undef);
    assert_short_len_R5: assert property (@(posedge clk) disable iff (rst)
        (start && vl_gran == '0) |=> undef);
endmodule

// File: tb/vec_unzip_tb.sv
`timescale 1ns/1ps
module vec_unzip_tb;
    localparam int VLEN = 512;
    localparam int GMAX = VLEN / 128;
    localparam int GW   = $clog2(GMAX + 1);

    logic            clk = 1'b0;
    logic            rst;
    logic            start;
    logic [VLEN-1:0] src_a, src_b;
    logic [GW-1:0]   vl_gran;
    logic [1:0]      size_code;
    logic            quad_mode, odd_sel, streaming, full_feat;
    logic            done, undef;
    logic [VLEN-1:0] result;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    vec_unzip #(.VLEN_MAX(VLEN)) u_dut (
        .clk(clk), .rst(rst), .start(start), .src_a(src_a), .src_b(src_b),
        .vl_gran(vl_gran), .size_code(size_code), .quad_mode(quad_mode),
        .odd_sel(odd_sel), .streaming(streaming), .full_feat(full_feat),
        .done(done), .undef(undef), .result(result)
    );

    task automatic check(input logic ok, input string tag,
                         input logic [VLEN-1:0] act, input logic [VLEN-1:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic void model(input logic [VLEN-1:0] a, input logic [VLEN-1:0] b,
                                  input int g, input int sz, input bit q, input bit part,
                                  input bit st, input bit ff,
                                  output logic [VLEN-1:0] res, output bit ud);
        int es, vl, pairs;
        es = q ? 128 : (8 << sz);
        vl = 128 * g;
        ud = (g == 0) || (g > GMAX) || (q && vl < 256) || (q && st && !ff);
        res = '0;
        if (!ud) begin
            pairs = vl / (2 * es);
            for (int p = 0; p < pairs; p++)
                for (int j = 0; j < es; j++) begin
                    res[p*es + j]         = a[(2*p + part)*es + j];
                    res[(pairs + p)*es + j] = b[(2*p + part)*es + j];
                end
        end
    endfunction

    task automatic fill();
        for (int i = 0; i < VLEN/32; i++) begin
            src_a[i*32 +: 32] = $urandom;
            src_b[i*32 +: 32] = $urandom;
        end
    endtask

    task automatic run_case(input int g, input int sz, input bit q, input bit part,
                            input bit st, input bit ff);
        logic [VLEN-1:0] exp_res;
        bit              exp_ud;
        string           utag, rtag;
        @(negedge clk);
        fill();
        vl_gran = GW'(g); size_code = 2'(sz); quad_mode = q; odd_sel = part;
        streaming = st; full_feat = ff; start = 1'b1;
        model(src_a, src_b, g, sz, q, part, st, ff, exp_res, exp_ud);
        if (g == 0 || g > GMAX) utag = "R5";
        else if (q && g < 2)    utag = "R6";
        else if (q)             utag = "R7";
        else                    utag = "R5";
        rtag = exp_ud ? "R8" : "R1 R2 R3 R4";
        @(negedge clk);
        start = 1'b0;
        check(done === 1'b1, "R9 done", VLEN'(done), VLEN'(1));
        check(undef === exp_ud, utag, VLEN'(undef), VLEN'(exp_ud));
        check(result === exp_res, rtag, result, exp_res);
        fill();
        @(negedge clk);
        check(done === 1'b0, "R9 done pulse", VLEN'(done), VLEN'(0));
        check(result === exp_res, "R9 hold", result, exp_res);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; start = 1'b0; src_a = '0; src_b = '0; vl_gran = '0;
        size_code = '0; quad_mode = 0; odd_sel = 0; streaming = 0; full_feat = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(done === 1'b0, "R10 done", VLEN'(done), VLEN'(0));
        check(undef === 1'b0, "R10 undef", VLEN'(undef), VLEN'(0));
        check(result === '0, "R10 result", result, '0);

        // R1 R2 R3 R4: every width code, both parts, every legal length
        for (int sz = 0; sz < 4; sz++)
            for (int part = 0; part < 2; part++)
                for (int g = 1; g <= GMAX; g++)
                    run_case(g, sz, 1'b0, part[0], 1'b0, 1'b0);
        // R7: streaming ignored outside quadword mode
        run_case(GMAX, 2, 1'b0, 1'b1, 1'b1, 1'b0);
        // R6 R7: quadword mode across lengths and streaming combinations
        for (int g = 1; g <= GMAX; g++)
            for (int s = 0; s < 4; s++)
                run_case(g, 3, 1'b1, s[0], s[1], s[0]);
        run_case(GMAX, 0, 1'b1, 1'b1, 1'b1, 1'b0);
        // R5: out-of-range granule counts
        for (int g = 0; g < (1 << GW); g++)
            if (g == 0 || g > GMAX) run_case(g, 1, 1'b0, 1'b0, 1'b0, 1'b0);

        // R10: reset after a live result
        run_case(GMAX, 0, 1'b0, 1'b1, 1'b0, 1'b0);
        @(negedge clk);
        start = 1'b1;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0; start = 1'b0;
        check(done === 1'b0, "R10 done after reset", VLEN'(done), VLEN'(0));
        check(result === '0, "R10 result after reset", result, '0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule